// File: doc/BRIEF.md
# Interprocessor Mailbox with Interrupts

This block lets two processors pass 32-bit messages to each other through four independent first-in first-out queues, each holding up to four messages. One side pushes a message by writing a queue's message register; the other side pops the oldest message by reading that same register. For each queue, software can read a full indication and a count of held messages. This lets a sender test for space before writing and a receiver test for data before reading.

Each queue raises two events. A new-message event fires on every accepted push. A not-full event fires when a pop frees a slot in a queue that was full. Every event sets a sticky bit in the status register of each user. Each user has its own enable register, and the user's interrupt line is high while any enabled status bit is set. Software clears a status bit by writing a one to it. The not-full event of queue m sits at bit 2m+1 and the new-message event at bit 2m.

Access is through a plain word-addressed register port. Register contents do not stream, so the port has no valid/ready pair and no back-pressure. A write takes effect at the clock edge where the write strobe is sampled. A read returns its data on `reg_rdata` one cycle later. Neither strobe can be stalled, and the bus master must space accesses itself.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-high reset, every queue is empty, every status and enable register is zero, and both interrupt lines are low.
- R2: Reading the message register of queue m (byte offset 0x040+4m) returns messages in the order they were written to that register.
- R3: A write to a queue that already holds 4 messages is discarded. The count stays 4 and the stored messages are unchanged.
- R4: A read from an empty queue returns zero, and the count stays zero.
- R5: The full-flag register of queue m (offset 0x080+4m) reads nonzero exactly while the queue holds 4 messages, and zero otherwise.
- R6: The count register of queue m (offset 0x0C0+4m) reads the number of messages held, from 0 to 4.
- R7: Every accepted push to queue m sets bit 2m in the status register of every user.
- R8: A pop from a full queue m sets bit 2m+1 in the status register of every user. A pop from a queue that was not full does not set it.
- R9: Writing the status register of user u (offset 0x100+8u) clears each bit written as one and leaves bits written as zero unchanged. The next read returns the updated value, and the other user's status is not affected.
- R10: The interrupt line of user u is high exactly when the bitwise AND of that user's status and its enable register (offset 0x104+8u, read/write, low 8 bits) is nonzero.
- R11: Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read.
- R12: The register at offset 0x000 is read-only. It returns the major revision in bits 7:4 and the minor revision in bits 3:0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 9 | Byte address of the accessed register |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_rd | input | 1 | Read strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq_line | output | 2 | Interrupt line per user |

## Verification
The queues are exercised with three patterns:
- A short burst of three messages, drained in order. This separates correct ordering from pointer mistakes.
- An overfill of five messages. This separates a discarded write from an overwrite of the head or tail.
- A pop from an empty queue. This separates a harmless zero from corruption of the count.

The event logic is driven by pushes and by pops taken both from a full queue and from a non-full queue. This shows whether not-full fires only on the full-to-not-full transition. Write-one-to-clear is tried with an all-zero mask and with a single-bit mask, on one user while the other is watched. Enable patterns that differ between the users separate the per-user gating of the interrupt lines.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned MSG_BASE   = 'h040;
  localparam int unsigned FULL_BASE  = 'h080;
  localparam int unsigned CNT_BASE   = 'h0C0;
  localparam int unsigned IRQ_BASE   = 'h100;
  localparam int unsigned IRQ_STRIDE = 8;
  localparam int unsigned IRQ_EN_OFS = 4;
  localparam int unsigned WORD_BYTES = 4;

  // Event pair produced by one queue per cycle
  typedef struct packed {
    logic not_full;
    logic new_msg;
  } q_evt_t;
endpackage

// File: rtl/ipc_mbox_queue.sv
module ipc_mbox_queue #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output ipc_mbox_pkg::q_evt_t evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  assign evt.new_msg  = push_ok;
  assign evt.not_full = pop_ok && full;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned NUM_USERS = 2,
  localparam int unsigned IW       = 2 * NUM_Q
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IW-1:0]                 set_evt,
  input  logic [NUM_USERS-1:0]          clr_wr,
  input  logic [NUM_USERS-1:0]          en_wr,
  input  logic [IW-1:0]                 wdata,
  output logic [NUM_USERS-1:0][IW-1:0]  stat,
  output logic [NUM_USERS-1:0][IW-1:0]  en,
  output logic [NUM_USERS-1:0]          irq
);
  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    always_ff @(posedge clk) begin
      if (rst) begin
        stat[u] <= '0;
        en[u]   <= '0;
      end else begin
        // a new event wins over a clear landing in the same cycle
        stat[u] <= (stat[u] & ~(clr_wr[u] ? wdata : '0)) | set_evt;
        if (en_wr[u]) en[u] <= wdata;
      end
    end
    assign irq[u] = |(stat[u] & en[u]);
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned NUM_USERS = 2,
  parameter int unsigned AW        = 9,
  parameter int unsigned REV_MAJOR = 2,
  parameter int unsigned REV_MINOR = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_USERS-1:0] irq_line
);
  import ipc_mbox_pkg::*;

  localparam int unsigned DW = BUS_W;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = 2 * NUM_Q;
  localparam logic [31:0] REV_WORD = {24'b0, 4'(REV_MAJOR), 4'(REV_MINOR)};

  logic [NUM_Q-1:0]                 msg_hit, q_push, q_pop, q_full, q_empty;
  logic [NUM_Q-1:0][DW-1:0]         q_head;
  logic [NUM_Q-1:0][CW-1:0]         q_count;
  q_evt_t [NUM_Q-1:0]               q_evt;
  logic [IW-1:0]                    evt_bits;
  logic [NUM_USERS-1:0]             stat_hit, en_hit;
  logic [NUM_USERS-1:0][IW-1:0]     irq_stat, irq_en;
  logic [31:0]                      rd_next;

  for (genvar m = 0; m < NUM_Q; m++) begin : g_q
    assign msg_hit[m] = (reg_addr == AW'(MSG_BASE + WORD_BYTES * m));
    assign q_push[m]  = reg_wr && msg_hit[m];
    assign q_pop[m]   = reg_rd && msg_hit[m];
    assign evt_bits[2*m]   = q_evt[m].new_msg;
    assign evt_bits[2*m+1] = q_evt[m].not_full;

    ipc_mbox_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[m]),
      .pop   (q_pop[m]),
      .wdata (reg_wdata),
      .head  (q_head[m]),
      .count (q_count[m]),
      .full  (q_full[m]),
      .empty (q_empty[m]),
      .evt   (q_evt[m])
    );
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_dec
    assign stat_hit[u] = reg_wr && (reg_addr == AW'(IRQ_BASE + IRQ_STRIDE * u));
    assign en_hit[u]   = reg_wr && (reg_addr == AW'(IRQ_BASE + IRQ_STRIDE * u + IRQ_EN_OFS));
  end

  ipc_mbox_irq #(.NUM_Q(NUM_Q), .NUM_USERS(NUM_USERS)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (evt_bits),
    .clr_wr  (stat_hit),
    .en_wr   (en_hit),
    .wdata   (reg_wdata[IW-1:0]),
    .stat    (irq_stat),
    .en      (irq_en),
    .irq     (irq_line)
  );

  // read mux, evaluated on pre-edge state
  always_comb begin
    rd_next = '0;
    if (reg_addr == '0) rd_next = REV_WORD;
    for (int m = 0; m < NUM_Q; m++) begin
      if (msg_hit[m])
        rd_next = q_empty[m] ? '0 : q_head[m];
      if (reg_addr == AW'(FULL_BASE + WORD_BYTES * m))
        rd_next = {31'b0, q_full[m]};
      if (reg_addr == AW'(CNT_BASE + WORD_BYTES * m))
        rd_next = 32'(q_count[m]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (reg_addr == AW'(IRQ_BASE + IRQ_STRIDE * u))
        rd_next = 32'(irq_stat[u]);
      if (reg_addr == AW'(IRQ_BASE + IRQ_STRIDE * u + IRQ_EN_OFS))
        rd_next = 32'(irq_en[u]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk #(
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned NUM_USERS = 2,
  parameter int unsigned AW        = 9,
  localparam int unsigned CW       = $clog2(DEPTH + 1),
  localparam int unsigned IW       = 2 * NUM_Q
) (
  input logic                         clk,
  input logic                         rst,
  input logic [AW-1:0]                reg_addr,
  input logic                         reg_wr,
  input logic                         reg_rd,
  input logic [31:0]                  reg_rdata,
  input logic [NUM_USERS-1:0]         irq_line,
  input logic [NUM_Q-1:0][CW-1:0]     q_count,
  input logic [NUM_USERS-1:0][IW-1:0] irq_stat,
  input logic [NUM_USERS-1:0][IW-1:0] irq_en
);
  import ipc_mbox_pkg::*;

  for (genvar m = 0; m < NUM_Q; m++) begin : g_qchk
    localparam logic [AW-1:0] MADDR = AW'(MSG_BASE + WORD_BYTES * m);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
      q_count[m] <= CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_rd && reg_addr == MADDR && q_count[m] == CW'(DEPTH))
        |=> $stable(q_count[m]));

    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (reg_rd && !reg_wr && reg_addr == MADDR && q_count[m] == '0)
        |=> (reg_rdata == '0) && (q_count[m] == '0));

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_uchk
      assert_newmsg_set_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == MADDR && q_count[m] < CW'(DEPTH))
          |=> irq_stat[u][2*m]);

      assert_notfull_set_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == MADDR && q_count[m] == CW'(DEPTH))
          |=> irq_stat[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_irqchk
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
      (irq_en[u] == '0) |-> !irq_line[u]);
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

bind ipc_mailbox ipc_mbox_chk #(
  .NUM_Q(NUM_Q), .DEPTH(DEPTH), .NUM_USERS(NUM_USERS), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq_line  (irq_line),
  .q_count   (q_count),
  .irq_stat  (irq_stat),
  .irq_en    (irq_en)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ipc_mailbox u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_check(input logic [8:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", 32'(irq_line), 32'h0);
    for (int m = 0; m < 4; m++) rd_check(9'(12'h0C0 + 4*m), 32'h0, "R1 count after reset");
    rd_check(9'h100, 32'h0, "R1 status u0");
    rd_check(9'h108, 32'h0, "R1 status u1");
    rd_check(9'h104, 32'h0, "R1 enable u0");
    bus_read(9'h000, v);
    check("R12 revision", v, 32'h21);
    bus_write(9'h000, 32'hFFFF_FFFF);
    rd_check(9'h000, 32'h21, "R12 revision after write");
  endtask

  task automatic t_fifo_order();
    bus_write(9'h040, 32'hA0A0_0001);
    bus_write(9'h040, 32'hB0B0_0002);
    bus_write(9'h040, 32'hC0C0_0003);
    rd_check(9'h0C0, 32'd3, "R6 count three");
    rd_check(9'h040, 32'hA0A0_0001, "R2 first");
    rd_check(9'h040, 32'hB0B0_0002, "R2 second");
    rd_check(9'h040, 32'hC0C0_0003, "R2 third");
    rd_check(9'h0C0, 32'd0, "R6 count drained");
  endtask

  task automatic t_latency();
    bus_write(9'h040, 32'hDEAD_BEEF);
    rd_check(9'h040, 32'hDEAD_BEEF, "R11 data one cycle after strobe");
    bus_write(9'h044, 32'h1234_5678);
    repeat (2) @(negedge clk);
    check("R11 rdata held", reg_rdata, 32'hDEAD_BEEF);
    rd_check(9'h044, 32'h1234_5678, "R11 tidy pop");
  endtask

  task automatic t_full();
    for (int i = 0; i < 5; i++) bus_write(9'h044, 32'h10 + 32'(i));
    rd_check(9'h084, 32'h1, "R5 full flag set");
    rd_check(9'h0C4, 32'd4, "R3 count stays four");
    for (int i = 0; i < 4; i++) rd_check(9'h044, 32'h10 + 32'(i), "R3 stored data intact");
    rd_check(9'h084, 32'h0, "R5 full flag clear");
  endtask

  task automatic t_empty();
    rd_check(9'h048, 32'h0, "R4 empty read zero");
    rd_check(9'h0C8, 32'h0, "R4 count stays zero");
  endtask

  task automatic t_newmsg();
    bus_write(9'h100, 32'hFF);
    bus_write(9'h108, 32'hFF);
    bus_write(9'h104, 32'h40);
    bus_write(9'h10C, 32'h00);
    bus_write(9'h04C, 32'h55);
    check("R10 only u0 irq", 32'(irq_line), 32'h1);
    rd_check(9'h100, 32'h40, "R7 u0 new-message bit 6");
    rd_check(9'h108, 32'h40, "R7 u1 new-message bit 6");
    rd_check(9'h104, 32'h40, "R10 enable readback");
    rd_check(9'h04C, 32'h55, "R7 tidy pop");
    bus_write(9'h100, 32'h40);
    check("R10 irq low after clear", 32'(irq_line), 32'h0);
    rd_check(9'h100, 32'h0, "R9 cleared readback");
  endtask

  task automatic t_notfull();
    for (int i = 0; i < 4; i++) bus_write(9'h048, 32'h200 + 32'(i));
    bus_write(9'h100, 32'hFF);
    bus_write(9'h108, 32'hFF);
    rd_check(9'h048, 32'h200, "R8 pop from full");
    rd_check(9'h100, 32'h20, "R8 not-full bit 5 u0");
    rd_check(9'h108, 32'h20, "R8 not-full bit 5 u1");
    bus_write(9'h100, 32'hFF);
    rd_check(9'h048, 32'h201, "R8 pop not from full");
    rd_check(9'h100, 32'h0, "R8 no event when not full");
    rd_check(9'h048, 32'h202, "R2 tidy");
    rd_check(9'h048, 32'h203, "R2 tidy");
  endtask

  task automatic t_w1c();
    bus_write(9'h100, 32'hFF);
    bus_write(9'h108, 32'hFF);
    bus_write(9'h040, 32'h1);
    bus_write(9'h044, 32'h2);
    bus_write(9'h108, 32'h00);
    rd_check(9'h108, 32'h05, "R9 zero write no effect");
    bus_write(9'h108, 32'h01);
    rd_check(9'h108, 32'h04, "R9 single bit cleared");
    rd_check(9'h100, 32'h05, "R9 other user untouched");
    bus_write(9'h10C, 32'h04);
    check("R10 u1 irq from bit 2", 32'(irq_line), 32'h2);
    bus_write(9'h10C, 32'h01);
    check("R10 u1 irq masked", 32'(irq_line), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fifo_order();
    t_latency();
    t_full();
    t_empty();
    t_newmsg();
    t_notfull();
    t_w1c();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule